// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbitration Scanner

This block decides which of a small set of transmit message buffers should be offered to the CAN bus next. It visits the buffers one at a time in index order and keeps a running best candidate. When the scan has visited every buffer, it reports whether a winner exists and, if so, which buffer it is. The protocol engine raises the start pulse at the points in a frame where the next message must be chosen, which are the CRC field and the error delimiter.

The winner is chosen under one of two policies. In index-order mode, the lowest-numbered eligible buffer wins. In key mode, the buffer with the numerically smallest arbitration key wins. The key is the identifier with the IDE and RTR bits placed at the positions they take on the wire. Three local priority bits can be placed above the key. A CPU write to a buffer's control/status word during a scan removes that buffer from the scan in progress, and only from that one.

There is no streaming data path. Every pin is a plain level or pulse, so no valid/ready back-pressure applies. The buffer fields are presented as flat vectors from the mailbox storage.

Top module: `can_tx_arb_scan`

## Requirements
- R1: After reset, busy_o, done_o and win_valid_o are 0 and win_idx_o is 0.
- R2: A transmit buffer whose 4-bit code is 4'b1000 or 4'b1001 never wins. Any other code on a transmit buffer makes it eligible.
- R3: A buffer with its mb_tx_i bit at 0 (receive) never wins, whatever its code, including 4'b0000.
- R4: With idx_order_i=1, the winner is the eligible buffer with the lowest index.
- R5: With idx_order_i=0, the winner is the eligible buffer with the lowest 32-bit key. A buffer's identifier field is 29 bits wide, with the base identifier in bits [28:18] and the extension in [17:0]. A standard frame (IDE=0) has the key {base, RTR, 1'b0, 19'b0}.
- R6: An extended frame (IDE=1) has the key {base, 1'b1, 1'b1, extension, RTR}. As a result, a standard data frame beats a standard remote frame with the same base, and that remote frame beats any extended frame with the same base.
- R7: With lprio_en_i=1, the buffer's 3-bit priority is placed above the key as its most significant bits, and a lower value wins. With lprio_en_i=0, the priority bits have no effect.
- R8: In key mode, when two keys are equal, the lower index wins.
- R9: A trig_i pulse sampled while idle starts a scan. busy_o is high for NUM_MB cycles, and done_o is a single-cycle pulse in the cycle after the last buffer is examined. That cycle is NUM_MB+1 cycles after the trigger edge. A trigger sampled while busy is ignored.
- R10: If cs_wr_i[k] is high in any cycle of a scan before or while buffer k is examined, buffer k cannot win that scan. The next scan includes it again.
- R11: When no buffer is eligible, win_valid_o=0 and win_idx_o=0. The result outputs change only in the cycle in which done_o is high, and they hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start-of-scan pulse |
| idx_order_i | input | 1 | 1: lowest index wins; 0: lowest key wins |
| lprio_en_i | input | 1 | Places the local priority bits above the key |
| mb_tx_i | input | NUM_MB | Per buffer, 1 = transmit buffer |
| mb_code_i | input | NUM_MB*4 | Per buffer, 4-bit code |
| mb_id_i | input | NUM_MB*29 | Per buffer, identifier (base in [28:18]) |
| mb_ide_i | input | NUM_MB | Per buffer, extended-frame flag |
| mb_rtr_i | input | NUM_MB | Per buffer, remote-frame flag |
| mb_prio_i | input | NUM_MB*PRIO_W | Per buffer, local priority |
| cs_wr_i | input | NUM_MB | Per buffer, CPU control/status write strobe |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| win_valid_o | output | 1 | A winner was found |
| win_idx_o | output | $clog2(NUM_MB) | Index of the winner |

## Verification
A scan counter that is off by one, or stuck, shows up at the ports directly. Either done_o arrives at a cycle other than NUM_MB+1 after the trigger, or it never arrives. An exclusion mask that is not cleared at a new scan shows up only one scan later, as a buffer that is eligible but missing from the next result. A wrong key layout or a wrong compare direction shows up in the first key-mode scan whose candidates differ only in IDE, RTR or priority. Each of these faults is therefore visible no later than the done_o pulse of the scan that exercises it.

// File: rtl/can_arb_pkg.sv
package can_arb_pkg;
  localparam int CODE_W = 4;
  localparam int ID_W   = 29;
  localparam int KEY_W  = 32;

  // Transmit codes that park a buffer outside arbitration
  function automatic logic tx_code_active(input logic [CODE_W-1:0] code);
    return !(code == 4'b1000 || code == 4'b1001);
  endfunction

  // Arbitration key with IDE/RTR where they travel on the wire
  function automatic logic [KEY_W-1:0] wire_key(input logic [ID_W-1:0] id,
                                                input logic ide,
                                                input logic rtr);
    if (ide)
      return {id[28:18], 1'b1, 1'b1, id[17:0], rtr};
    else
      return {id[28:18], rtr, 1'b0, 19'b0};
  endfunction
endpackage

// File: rtl/can_arb_key.sv
module can_arb_key
  import can_arb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(NUM_MB),
  localparam int FKEY_W = PRIO_W + KEY_W
) (
  input  logic [IDX_W-1:0]         sel_i,
  input  logic                     lprio_en_i,
  input  logic [NUM_MB-1:0]        mb_tx_i,
  input  logic [NUM_MB*CODE_W-1:0] mb_code_i,
  input  logic [NUM_MB*ID_W-1:0]   mb_id_i,
  input  logic [NUM_MB-1:0]        mb_ide_i,
  input  logic [NUM_MB-1:0]        mb_rtr_i,
  input  logic [NUM_MB*PRIO_W-1:0] mb_prio_i,
  output logic [FKEY_W-1:0]        key_o,
  output logic                     active_o
);
  logic [CODE_W-1:0] code;
  logic [ID_W-1:0]   id;
  logic [PRIO_W-1:0] prio;

  always_comb begin
    code     = mb_code_i[int'(sel_i)*CODE_W +: CODE_W];
    id       = mb_id_i[int'(sel_i)*ID_W +: ID_W];
    prio     = mb_prio_i[int'(sel_i)*PRIO_W +: PRIO_W];
    active_o = mb_tx_i[sel_i] && tx_code_active(code);
    key_o    = {(lprio_en_i ? prio : {PRIO_W{1'b0}}),
                wire_key(id, mb_ide_i[sel_i], mb_rtr_i[sel_i])};
  end
endmodule

// File: rtl/can_arb_seq.sv
module can_arb_seq #(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [NUM_MB-1:0] cs_wr_i,
  output logic              busy_o,
  output logic              start_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [NUM_MB-1:0] excl_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MB - 1);

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [NUM_MB-1:0] excl_q;

  assign start_o = trig_i && !busy_q;
  assign last_o  = busy_q && (idx_q == LAST_IDX);
  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign excl_o  = excl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      excl_q <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      excl_q <= '0;
    end else if (busy_q) begin
      excl_q <= excl_q | cs_wr_i;
      idx_q  <= last_o ? '0 : idx_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/can_arb_best.sv
module can_arb_best #(
  parameter int NUM_MB = 16,
  parameter int FKEY_W = 35,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              last_i,
  input  logic              idx_order_i,
  input  logic              elig_i,
  input  logic [FKEY_W-1:0] key_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NUM_MB-1:0] cs_wr_i,
  output logic              done_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic              have_q;
  logic [FKEY_W-1:0] best_key_q;
  logic [IDX_W-1:0]  best_idx_q;
  logic              kill, have_eff, take;

  always_comb begin
    kill     = have_q && cs_wr_i[best_idx_q];
    have_eff = have_q && !kill;
    take     = elig_i && (!have_eff || (!idx_order_i && (key_i < best_key_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      best_key_q <= '0;
      best_idx_q <= '0;
      done_o     <= 1'b0;
      valid_o    <= 1'b0;
      win_idx_o  <= '0;
    end else begin
      done_o <= last_i;
      if (start_i) begin
        have_q     <= 1'b0;
        best_key_q <= '0;
        best_idx_q <= '0;
      end else if (busy_i) begin
        if (take) begin
          have_q     <= 1'b1;
          best_key_q <= key_i;
          best_idx_q <= idx_i;
        end else if (kill) begin
          have_q <= 1'b0;
        end
        if (last_i) begin
          valid_o   <= take || have_eff;
          win_idx_o <= take ? idx_i : (have_eff ? best_idx_q : '0);
        end
      end
    end
  end
endmodule

// File: rtl/can_tx_arb_scan.sv
module can_tx_arb_scan
  import can_arb_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int PRIO_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig_i,
  input  logic                          idx_order_i,
  input  logic                          lprio_en_i,
  input  logic [NUM_MB-1:0]             mb_tx_i,
  input  logic [NUM_MB*4-1:0]           mb_code_i,
  input  logic [NUM_MB*29-1:0]          mb_id_i,
  input  logic [NUM_MB-1:0]             mb_ide_i,
  input  logic [NUM_MB-1:0]             mb_rtr_i,
  input  logic [NUM_MB*PRIO_W-1:0]      mb_prio_i,
  input  logic [NUM_MB-1:0]             cs_wr_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          win_valid_o,
  output logic [$clog2(NUM_MB)-1:0]     win_idx_o
);
  localparam int IDX_W  = $clog2(NUM_MB);
  localparam int FKEY_W = PRIO_W + KEY_W;

  logic              start, last, active, elig;
  logic [IDX_W-1:0]  idx;
  logic [NUM_MB-1:0] excl;
  logic [FKEY_W-1:0] key;

  can_arb_seq #(.NUM_MB(NUM_MB)) u_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cs_wr_i(cs_wr_i),
    .busy_o(busy_o), .start_o(start), .last_o(last), .idx_o(idx), .excl_o(excl)
  );

  can_arb_key #(.NUM_MB(NUM_MB), .PRIO_W(PRIO_W)) u_key (
    .sel_i(idx), .lprio_en_i(lprio_en_i), .mb_tx_i(mb_tx_i),
    .mb_code_i(mb_code_i), .mb_id_i(mb_id_i), .mb_ide_i(mb_ide_i),
    .mb_rtr_i(mb_rtr_i), .mb_prio_i(mb_prio_i), .key_o(key), .active_o(active)
  );

  // a write in this cycle or earlier in the scan removes the buffer
  assign elig = active && !excl[idx] && !cs_wr_i[idx];

  can_arb_best #(.NUM_MB(NUM_MB), .FKEY_W(FKEY_W)) u_best (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy_o), .last_i(last),
    .idx_order_i(idx_order_i), .elig_i(elig), .key_i(key), .idx_i(idx),
    .cs_wr_i(cs_wr_i), .done_o(done_o), .valid_o(win_valid_o), .win_idx_o(win_idx_o)
  );
endmodule

// File: rtl/can_tx_arb_scan_chk.sv
module can_tx_arb_scan_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             win_valid_o,
  input logic [IDX_W-1:0] win_idx_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R9
  scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_i));
  // R11
  novalid_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> (win_idx_o == '0));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(win_valid_o) && $stable(win_idx_o)));
endmodule

bind can_tx_arb_scan can_tx_arb_scan_chk #(.IDX_W($clog2(NUM_MB))) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .busy_o(busy_o),
  .done_o(done_o), .win_valid_o(win_valid_o), .win_idx_o(win_idx_o)
);

// File: tb/can_tx_arb_scan_tb.sv
module can_tx_arb_scan_tb;
  localparam int N = 16;
  localparam int PW = 3;

  typedef struct packed {
    logic [3:0]  i;
    logic        tx;
    logic [3:0]  code;
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic [2:0]  prio;
  } mb_t;

  typedef struct packed {
    logic imode;
    logic lpen;
    mb_t  a;
    mb_t  b;
    mb_t  c;
    logic ev;
    logic [3:0] ei;
  } vec_t;

  localparam mb_t NONE = '{4'd0, 1'b1, 4'b1000, 29'd0, 1'b0, 1'b0, 3'd0};
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R5 lowest standard id
    '{1'b0,1'b0,'{4'd3,1'b1,4'hC,{11'h100,18'h0},1'b0,1'b0,3'd0},'{4'd7,1'b1,4'hC,{11'h080,18'h0},1'b0,1'b0,3'd0},'{4'd12,1'b1,4'hC,{11'h200,18'h0},1'b0,1'b0,3'd0},1'b1,4'd7},
    // R4 index order
    '{1'b1,1'b0,'{4'd3,1'b1,4'hC,{11'h100,18'h0},1'b0,1'b0,3'd0},'{4'd7,1'b1,4'hC,{11'h080,18'h0},1'b0,1'b0,3'd0},'{4'd12,1'b1,4'hC,{11'h200,18'h0},1'b0,1'b0,3'd0},1'b1,4'd3},
    // R5 data beats remote
    '{1'b0,1'b0,'{4'd2,1'b1,4'hC,{11'h123,18'h0},1'b0,1'b1,3'd0},'{4'd5,1'b1,4'hC,{11'h123,18'h0},1'b0,1'b0,3'd0},NONE,1'b1,4'd5},
    // R6 standard beats extended
    '{1'b0,1'b0,'{4'd1,1'b1,4'hC,{11'h123,18'h0},1'b1,1'b0,3'd0},'{4'd9,1'b1,4'hC,{11'h123,18'h0},1'b0,1'b0,3'd0},NONE,1'b1,4'd9},
    // R6 extension bits order
    '{1'b0,1'b0,'{4'd4,1'b1,4'hC,{11'h050,18'h3FFFF},1'b1,1'b0,3'd0},'{4'd6,1'b1,4'hC,{11'h050,18'h00001},1'b1,1'b0,3'd0},'{4'd10,1'b1,4'hC,{11'h051,18'h0},1'b0,1'b0,3'd0},1'b1,4'd6},
    // R7 local priority on
    '{1'b0,1'b1,'{4'd0,1'b1,4'hC,{11'h001,18'h0},1'b0,1'b0,3'd5},'{4'd8,1'b1,4'hC,{11'h700,18'h0},1'b0,1'b0,3'd2},'{4'd15,1'b1,4'hC,{11'h7FF,18'h0},1'b0,1'b0,3'd2},1'b1,4'd8},
    // R7 local priority off
    '{1'b0,1'b0,'{4'd0,1'b1,4'hC,{11'h001,18'h0},1'b0,1'b0,3'd5},'{4'd8,1'b1,4'hC,{11'h700,18'h0},1'b0,1'b0,3'd2},'{4'd15,1'b1,4'hC,{11'h7FF,18'h0},1'b0,1'b0,3'd2},1'b1,4'd0},
    // R8 equal keys
    '{1'b0,1'b0,'{4'd3,1'b1,4'hA,{11'h0AA,18'h0},1'b0,1'b0,3'd0},'{4'd11,1'b1,4'hC,{11'h0AA,18'h0},1'b0,1'b0,3'd0},'{4'd14,1'b1,4'hE,{11'h0AA,18'h0},1'b0,1'b0,3'd0},1'b1,4'd3},
    // R2 inactive transmit codes
    '{1'b0,1'b0,'{4'd1,1'b1,4'b1000,{11'h001,18'h0},1'b0,1'b0,3'd0},'{4'd2,1'b1,4'b1001,{11'h002,18'h0},1'b0,1'b0,3'd0},'{4'd9,1'b1,4'hC,{11'h400,18'h0},1'b0,1'b0,3'd0},1'b1,4'd9},
    // R3 receive buffers, key mode
    '{1'b0,1'b0,'{4'd0,1'b0,4'h4,{11'h000,18'h0},1'b0,1'b0,3'd0},'{4'd5,1'b0,4'h0,{11'h000,18'h0},1'b0,1'b0,3'd0},'{4'd13,1'b1,4'hC,{11'h7FF,18'h0},1'b0,1'b0,3'd0},1'b1,4'd13},
    // R3 receive buffers, index mode
    '{1'b1,1'b0,'{4'd0,1'b0,4'h4,{11'h000,18'h0},1'b0,1'b0,3'd0},'{4'd5,1'b0,4'h0,{11'h000,18'h0},1'b0,1'b0,3'd0},'{4'd13,1'b1,4'hC,{11'h7FF,18'h0},1'b0,1'b0,3'd0},1'b1,4'd13},
    // R11 nothing eligible
    '{1'b0,1'b0,'{4'd0,1'b0,4'h2,{11'h000,18'h0},1'b0,1'b0,3'd0},'{4'd1,1'b1,4'b1000,{11'h001,18'h0},1'b0,1'b0,3'd0},'{4'd2,1'b1,4'b1001,{11'h002,18'h0},1'b0,1'b0,3'd0},1'b0,4'd0},
    // R6 extended data beats extended remote
    '{1'b0,1'b0,'{4'd3,1'b1,4'hC,{11'h010,18'h00005},1'b1,1'b1,3'd0},'{4'd4,1'b1,4'hC,{11'h010,18'h00005},1'b1,1'b0,3'd0},NONE,1'b1,4'd4},
    // R4 index order skips inactive codes
    '{1'b1,1'b0,'{4'd0,1'b1,4'b1000,{11'h000,18'h0},1'b0,1'b0,3'd0},'{4'd6,1'b1,4'hA,{11'h7FF,18'h0},1'b0,1'b0,3'd0},'{4'd2,1'b1,4'b1001,{11'h000,18'h0},1'b0,1'b0,3'd0},1'b1,4'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0;
  logic idx_order_i = 1'b0;
  logic lprio_en_i = 1'b0;
  logic [N-1:0]    mb_tx_i;
  logic [N*4-1:0]  mb_code_i;
  logic [N*29-1:0] mb_id_i;
  logic [N-1:0]    mb_ide_i;
  logic [N-1:0]    mb_rtr_i;
  logic [N*PW-1:0] mb_prio_i;
  logic [N-1:0]    cs_wr_i;
  logic busy_o, done_o, win_valid_o;
  logic [3:0] win_idx_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_tx_arb_scan #(.NUM_MB(N), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .idx_order_i(idx_order_i),
    .lprio_en_i(lprio_en_i), .mb_tx_i(mb_tx_i), .mb_code_i(mb_code_i),
    .mb_id_i(mb_id_i), .mb_ide_i(mb_ide_i), .mb_rtr_i(mb_rtr_i),
    .mb_prio_i(mb_prio_i), .cs_wr_i(cs_wr_i), .busy_o(busy_o), .done_o(done_o),
    .win_valid_o(win_valid_o), .win_idx_o(win_idx_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int k = 0; k < N; k++) begin
      mb_tx_i[k] = 1'b1;
      mb_code_i[k*4 +: 4] = 4'b1000;
      mb_id_i[k*29 +: 29] = '0;
      mb_ide_i[k] = 1'b0;
      mb_rtr_i[k] = 1'b0;
      mb_prio_i[k*PW +: PW] = '0;
    end
    cs_wr_i = '0;
  endtask

  task automatic put(input mb_t m);
    mb_tx_i[m.i] = m.tx;
    mb_code_i[m.i*4 +: 4] = m.code;
    mb_id_i[m.i*29 +: 29] = m.id;
    mb_ide_i[m.i] = m.ide;
    mb_rtr_i[m.i] = m.rtr;
    mb_prio_i[m.i*PW +: PW] = m.prio;
  endtask

  // pulse trigger, wait for the expected done cycle, sample at a negedge
  task automatic run_scan(input string req);
    @(negedge clk) trig_i = 1'b1;
    @(negedge clk) trig_i = 1'b0;
    repeat (N) @(posedge clk);
    @(negedge clk);
    check(done_o === 1'b1, req, int'(done_o), 1);
  endtask

  function automatic string vtag(input int v);
    case (v)
      0, 2: return "R5";
      1, 13: return "R4";
      3, 4, 12: return "R6";
      5, 6: return "R7";
      7: return "R8";
      8: return "R2";
      9, 10: return "R3";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 busy/done", int'({busy_o, done_o}), 0);
    check(win_valid_o === 1'b0 && win_idx_o === 4'd0, "R1 result", int'(win_idx_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_all();
      idx_order_i = VECS[v].imode;
      lprio_en_i  = VECS[v].lpen;
      put(VECS[v].c);
      put(VECS[v].b);
      put(VECS[v].a);
      run_scan({vtag(v), " done"});
      check(win_valid_o === VECS[v].ev, {vtag(v), " valid"}, int'(win_valid_o), int'(VECS[v].ev));
      check(win_idx_o === VECS[v].ei, {vtag(v), " index"}, int'(win_idx_o), int'(VECS[v].ei));
    end

    // R9 exact timing, busy span and a trigger during busy
    clear_all();
    idx_order_i = 1'b0;
    lprio_en_i = 1'b0;
    put('{4'd4, 1'b1, 4'hC, {11'h033, 18'h0}, 1'b0, 1'b0, 3'd0});
    @(negedge clk) trig_i = 1'b1;
    @(negedge clk) trig_i = 1'b0;
    for (int c = 1; c < N; c++) begin
      check(busy_o === 1'b1 && done_o === 1'b0, "R9 busy span", int'({busy_o, done_o}), 2);
      if (c == 3) trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
    end
    check(busy_o === 1'b1 && done_o === 1'b0, "R9 last busy", int'({busy_o, done_o}), 2);
    @(negedge clk);
    check(done_o === 1'b1 && busy_o === 1'b0, "R9 done cycle", int'({busy_o, done_o}), 1);
    check(win_idx_o === 4'd4, "R9 winner", int'(win_idx_o), 4);
    for (int c = 0; c < N + 2; c++) begin
      @(negedge clk);
      check(done_o === 1'b0 && busy_o === 1'b0, "R9 ignored trigger", int'({busy_o, done_o}), 0);
    end

    // R10 write to a not-yet-examined buffer drops it for this scan
    clear_all();
    put('{4'd5, 1'b1, 4'hC, {11'h001, 18'h0}, 1'b0, 1'b0, 3'd0});
    put('{4'd9, 1'b1, 4'hC, {11'h300, 18'h0}, 1'b0, 1'b0, 3'd0});
    @(negedge clk) trig_i = 1'b1;
    @(negedge clk) trig_i = 1'b0;
    cs_wr_i[5] = 1'b1;
    @(negedge clk) cs_wr_i = '0;
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    check(done_o === 1'b1, "R10 done", int'(done_o), 1);
    check(win_valid_o === 1'b1 && win_idx_o === 4'd9, "R10 excluded", int'(win_idx_o), 9);
    run_scan("R10 rescan done");
    check(win_idx_o === 4'd5, "R10 next scan", int'(win_idx_o), 5);

    // R11 results hold between scans while buffers change
    clear_all();
    put('{4'd1, 1'b1, 4'hC, {11'h000, 18'h0}, 1'b0, 1'b0, 3'd0});
    repeat (4) @(negedge clk);
    check(win_valid_o === 1'b1 && win_idx_o === 4'd5, "R11 hold", int'(win_idx_o), 5);
    run_scan("R11 done");
    check(win_idx_o === 4'd1, "R11 update", int'(win_idx_o), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule